// File: doc/BRIEF.md
# Serial Bit-Clock and Frame-Sync Generator

This block is the master-side timing source of a synchronous serial audio port. It divides the functional clock by a programmable 8-bit ratio to form the serial bit clock. It then counts bit clocks to place a frame-sync pulse whose frame length and active length are set separately. All outputs are registered or derived from registers in the functional clock domain. The block also gives a one-cycle bit strobe (`bit_tick`), which marks each bit-clock period, and a one-cycle `frame_start` strobe on the bit that opens a frame.

Two independent run controls gate the logic. `gen_run` lets the divider count, and `fs_run` lets the frame counter count. The frame counter only moves while both are high, so frame sync can never precede the bit clock. Frame timing comes from the raw period and width fields, from a symmetric preset sized by the sample word length, or from the raw fields clamped to a legal window. In periodic mode, frames repeat without further action. In write-triggered mode, each data-write pulse opens exactly one frame. The block moves no data, so it has no valid/ready stream interface. Every pin is a plain control or status level.

Top module: `srg_fsgen`

## Requirements
- R1: With `gen_run` high and `cfg_div` = D held constant, `bit_tick` pulses once every D+1 clock cycles. With D = 0 it is high on every cycle.
- R2: While `gen_run` is low, `bit_tick` and `frame_start` stay low, `bclk` equals `bclk_pol`, and `fsync` equals `fs_pol`.
- R3: With `gen_run` high, any D+1 consecutive cycles contain exactly floor(D/2)+1 cycles in which `bclk` is at the level opposite to `bclk_pol`. `bclk_pol` = 0 makes that level high, and `bclk_pol` = 1 inverts it.
- R4: While `fs_run` is low, `frame_start` stays low and `fsync` is at its inactive level.
- R5: In periodic mode, the first `bit_tick` after `fs_run` is seen high (with `gen_run` high) carries `frame_start`.
- R6: In periodic mode (`cfg_fs_auto` = 1) with field timing (`cfg_mode` 0 or 3), `frame_start` repeats every P+1 bit strobes, where P = `cfg_period`.
- R7: `fsync` is active on the frame-start strobe and on the following strobes, W+1 strobes in all (W = frame width). If W ≥ P, it stays active for the whole frame.
- R8: `fs_pol` = 0 makes the active `fsync` level high; `fs_pol` = 1 makes it low.
- R9: In symmetric mode (`cfg_mode` = 1), a frame lasts 16·B strobes and `fsync` is active for 8·B of them, where B = `cfg_wbytes` (0 is taken as 1). `cfg_period` and `cfg_width` have no effect in this mode.
- R10: In clamped mode (`cfg_mode` = 2), the frame length is P+1 limited to the range 33 to 4095 strobes, and `cfg_width` still sets the active length.
- R11: In write-triggered mode (`cfg_fs_auto` = 0), no frame starts without a `data_wr` pulse. Each pulse opens exactly one frame on a later strobe, and `fsync` is then active for W+1 strobes before going inactive.
- R12: `frame_start` is only ever high in a cycle in which `bit_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_run | input | 1 | 1 lets the bit-clock divider run |
| fs_run | input | 1 | 1 lets the frame counter run (needs gen_run) |
| cfg_div | input | 8 | Divide ratio minus one |
| cfg_mode | input | 2 | 0/3 raw fields, 1 symmetric, 2 clamped |
| cfg_wbytes | input | 3 | Sample word length in bytes, symmetric mode |
| cfg_period | input | 12 | Frame length in bit clocks minus one |
| cfg_width | input | 8 | Frame-sync active length minus one |
| cfg_fs_auto | input | 1 | 1 periodic frames, 0 write-triggered frames |
| data_wr | input | 1 | Data-write pulse, used in write-triggered mode |
| bclk_pol | input | 1 | Bit-clock output inversion |
| fs_pol | input | 1 | Frame-sync polarity, 1 = active low |
| bclk | output | 1 | Serial bit clock |
| bit_tick | output | 1 | One-cycle strobe per bit clock |
| fsync | output | 1 | Frame-sync level |
| frame_start | output | 1 | One-cycle strobe on the first bit of a frame |

## Verification
The bit-spacing assertion assumes that `cfg_div` changes only while `gen_run` is low. Its checker forgets the previous strobe whenever the generator is stopped, and the stimulus always drops `gen_run` for a cycle before loading a new divide ratio. The polarity and frame-start assertions assume that `fs_pol` is not changed in the same cycle as a frame start. The stimulus changes polarity and mode only on falling clock edges and measures a frame only after the next full frame has begun. Periods near the clamp limits are run with a divide ratio of zero so that a whole frame fits within a short window.

// File: rtl/srg_pkg.sv
package srg_pkg;

  typedef enum logic [1:0] {
    FMODE_FIELD  = 2'd0,
    FMODE_SYMM   = 2'd1,
    FMODE_CLAMP  = 2'd2,
    FMODE_FIELD2 = 2'd3
  } fmode_e;

  // Smallest legal frame length in bit clocks for the clamped mode.
  localparam int unsigned CLAMP_MIN_BITS = 33;

  // Symmetric preset: frame bits per word byte and active bits per word byte.
  localparam int unsigned SYM_PER_SHIFT = 4;
  localparam int unsigned SYM_WID_SHIFT = 3;

endpackage

// File: rtl/srg_bitclk.sv
module srg_bitclk #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick_c,
  output logic             tick_q,
  output logic             level
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;

  assign half   = div >> 1;
  // ">=" keeps the counter bounded if the ratio is lowered mid-count
  assign tick_c = run && (cnt_q >= div);
  assign level  = run && (cnt_q <= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_c;
      if (!run || tick_c) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/srg_shape.sv
module srg_shape
  import srg_pkg::*;
#(
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8,
  parameter int unsigned WB_W  = 3
) (
  input  logic [1:0]       mode,
  input  logic [WB_W-1:0]  wbytes,
  input  logic [PER_W-1:0] period,
  input  logic [WID_W-1:0] width,
  output logic [PER_W-1:0] per_eff,
  output logic [WID_W-1:0] wid_eff
);

  localparam logic [PER_W-1:0] CLAMP_LO = PER_W'(CLAMP_MIN_BITS - 1);
  localparam logic [PER_W-1:0] CLAMP_HI = {{(PER_W-1){1'b1}}, 1'b0};

  logic [WB_W-1:0]  bytes_n;
  logic [PER_W-1:0] per_sym;
  logic [WID_W-1:0] wid_sym;
  logic [PER_W-1:0] per_clamp;

  assign bytes_n = (wbytes == '0) ? WB_W'(1) : wbytes;
  assign per_sym = (PER_W'(bytes_n) << SYM_PER_SHIFT) - 1'b1;
  assign wid_sym = (WID_W'(bytes_n) << SYM_WID_SHIFT) - 1'b1;

  always_comb begin
    if (period < CLAMP_LO) begin
      per_clamp = CLAMP_LO;
    end else if (period > CLAMP_HI) begin
      per_clamp = CLAMP_HI;
    end else begin
      per_clamp = period;
    end
  end

  always_comb begin
    unique case (fmode_e'(mode))
      FMODE_SYMM: begin
        per_eff = per_sym;
        wid_eff = wid_sym;
      end
      FMODE_CLAMP: begin
        per_eff = per_clamp;
        wid_eff = width;
      end
      default: begin
        per_eff = period;
        wid_eff = width;
      end
    endcase
  end

endmodule

// File: rtl/srg_framer.sv
module srg_framer #(
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic             auto_mode,
  input  logic             wr,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  output logic             active_q,
  output logic             fstart_q
);

  localparam int unsigned CW = PER_W + 1;

  logic [PER_W-1:0] fcnt_q;
  logic             started_q;
  logic             pend_q;
  logic             start_c;
  logic [CW-1:0]    cnt_inc;
  logic [CW-1:0]    wid_ext;
  logic             in_width;

  assign cnt_inc  = {1'b0, fcnt_q} + 1'b1;
  assign wid_ext  = CW'(wid);
  assign in_width = started_q && (cnt_inc <= wid_ext);

  always_comb begin
    if (auto_mode) begin
      start_c = !started_q || (fcnt_q >= per);
    end else begin
      start_c = pend_q || wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q    <= '0;
      started_q <= 1'b0;
      pend_q    <= 1'b0;
      active_q  <= 1'b0;
      fstart_q  <= 1'b0;
    end else if (!go) begin
      fcnt_q    <= '0;
      started_q <= 1'b0;
      pend_q    <= 1'b0;
      active_q  <= 1'b0;
      fstart_q  <= 1'b0;
    end else if (tick) begin
      fstart_q <= start_c;
      if (start_c) begin
        fcnt_q    <= '0;
        started_q <= 1'b1;
        pend_q    <= 1'b0;
        active_q  <= 1'b1;
      end else begin
        pend_q   <= 1'b0;
        active_q <= in_width;
        if (auto_mode || (CW'(fcnt_q) <= wid_ext)) begin
          fcnt_q <= cnt_inc[PER_W-1:0];
        end
      end
    end else begin
      fstart_q <= 1'b0;
      pend_q   <= !auto_mode && (pend_q || wr);
    end
  end

endmodule

// File: rtl/srg_fsgen.sv
module srg_fsgen #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8,
  parameter int unsigned WB_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_run,
  input  logic             fs_run,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_mode,
  input  logic [WB_W-1:0]  cfg_wbytes,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_fs_auto,
  input  logic             data_wr,
  input  logic             bclk_pol,
  input  logic             fs_pol,
  output logic             bclk,
  output logic             bit_tick,
  output logic             fsync,
  output logic             frame_start
);

  logic             tick_c;
  logic             bclk_lvl;
  logic             fs_go;
  logic             fs_act;
  logic [PER_W-1:0] per_eff;
  logic [WID_W-1:0] wid_eff;

  // frame counting is only allowed once the divider runs
  assign fs_go = fs_run && gen_run;

  srg_bitclk #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (gen_run),
    .div    (cfg_div),
    .tick_c (tick_c),
    .tick_q (bit_tick),
    .level  (bclk_lvl)
  );

  srg_shape #(.PER_W(PER_W), .WID_W(WID_W), .WB_W(WB_W)) u_shape (
    .mode    (cfg_mode),
    .wbytes  (cfg_wbytes),
    .period  (cfg_period),
    .width   (cfg_width),
    .per_eff (per_eff),
    .wid_eff (wid_eff)
  );

  srg_framer #(.PER_W(PER_W), .WID_W(WID_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (fs_go),
    .tick      (tick_c),
    .auto_mode (cfg_fs_auto),
    .wr        (data_wr),
    .per       (per_eff),
    .wid       (wid_eff),
    .active_q  (fs_act),
    .fstart_q  (frame_start)
  );

  assign bclk  = bclk_lvl ^ bclk_pol;
  assign fsync = fs_act ^ fs_pol;

endmodule

// File: rtl/srg_fsgen_chk.sv
module srg_fsgen_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_run,
  input logic             fs_run,
  input logic [DIV_W-1:0] cfg_div,
  input logic             fs_pol,
  input logic             bit_tick,
  input logic             fsync,
  input logic             frame_start
);

  localparam int unsigned GW = DIV_W + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= gen_run && (seen_q || bit_tick);
      if (bit_tick) begin
        gap_q <= GW'(1);
      end else if (gap_q != {GW{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && seen_q) |-> (gap_q == (GW'(cfg_div) + 1'b1)));  // R1

  AST_GEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_run |=> (!bit_tick && !frame_start));  // R2

  AST_FS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_run |=> !frame_start);  // R4

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (fsync != fs_pol));  // R8

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_tick);  // R12

endmodule

bind srg_fsgen srg_fsgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_run     (gen_run),
  .fs_run      (fs_run),
  .cfg_div     (cfg_div),
  .fs_pol      (fs_pol),
  .bit_tick    (bit_tick),
  .fsync       (fsync),
  .frame_start (frame_start)
);

// File: tb/tb_srg_fsgen.sv
module tb_srg_fsgen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_run = 1'b0;
  logic        fs_run = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic [1:0]  cfg_mode = '0;
  logic [2:0]  cfg_wbytes = '0;
  logic [11:0] cfg_period = '0;
  logic [7:0]  cfg_width = '0;
  logic        cfg_fs_auto = 1'b1;
  logic        data_wr = 1'b0;
  logic        bclk_pol = 1'b0;
  logic        fs_pol = 1'b0;
  logic        bclk, bit_tick, fsync, frame_start;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  srg_fsgen dut (
    .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_run(fs_run),
    .cfg_div(cfg_div), .cfg_mode(cfg_mode), .cfg_wbytes(cfg_wbytes),
    .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_fs_auto(cfg_fs_auto),
    .data_wr(data_wr), .bclk_pol(bclk_pol), .fs_pol(fs_pol),
    .bclk(bclk), .bit_tick(bit_tick), .fsync(fsync), .frame_start(frame_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_div(input int d);
    gen_run = 1'b0;
    step();
    cfg_div = 8'(d);
    gen_run = 1'b1;
  endtask

  // cycles between two consecutive strobes
  task automatic tick_gap(output int gap);
    int n = 0;
    gap = -1;
    while (!bit_tick && n < 1000) begin step(); n++; end
    for (int i = 1; i < 1000; i++) begin
      step();
      if (bit_tick) begin gap = i; break; end
    end
  endtask

  // waits for a frame start, then counts strobes up to the next one
  // and strobes with fsync active inside that frame
  task automatic measure_frame(output int nticks, output int nact);
    int n = 0;
    bit found = 0;
    nticks = -1;
    nact = -1;
    step();
    while (!frame_start && n < 20000) begin step(); n++; end
    if (!frame_start) return;
    nticks = 0;
    nact = (fsync != fs_pol) ? 1 : 0;
    for (int i = 0; i < 20000; i++) begin
      step();
      if (bit_tick) begin
        nticks++;
        if (frame_start) begin found = 1; break; end
        if (fsync != fs_pol) nact++;
      end
    end
    if (!found) nticks = -1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(bit_tick == 0 && frame_start == 0, "R2 reset strobes", int'(bit_tick), 0);
    chk(fsync == 0 && bclk == 0, "R2 reset levels", int'({fsync, bclk}), 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_divider();
    int g;
    set_div(3);
    tick_gap(g); chk(g == 4, "R1 div=3", g, 4);
    set_div(0);
    tick_gap(g); chk(g == 1, "R1 div=0", g, 1);
    set_div(6);
    tick_gap(g); chk(g == 7, "R1 div=6", g, 7);
  endtask

  task automatic t_bclk();
    int hi;
    set_div(3);
    repeat (10) step();
    hi = 0;
    for (int i = 0; i < 4; i++) begin step(); if (bclk) hi++; end
    chk(hi == 2, "R3 duty div=3", hi, 2);
    set_div(4);
    repeat (10) step();
    hi = 0;
    for (int i = 0; i < 5; i++) begin step(); if (bclk) hi++; end
    chk(hi == 3, "R3 duty div=4", hi, 3);
    bclk_pol = 1'b1;
    hi = 0;
    for (int i = 0; i < 5; i++) begin step(); if (!bclk) hi++; end
    chk(hi == 3, "R3 inverted duty div=4", hi, 3);
    bclk_pol = 1'b0;
  endtask

  task automatic t_gen_stop();
    int bad = 0;
    fs_run = 1'b1;
    gen_run = 1'b0;
    bclk_pol = 1'b1;
    fs_pol = 1'b1;
    step();
    for (int i = 0; i < 20; i++) begin
      step();
      if (bit_tick || frame_start || bclk != 1'b1 || fsync != 1'b1) bad++;
    end
    chk(bad == 0, "R2 generator stopped", bad, 0);
    bclk_pol = 1'b0;
    fs_pol = 1'b0;
    fs_run = 1'b0;
  endtask

  task automatic t_fs_stop();
    int bad = 0;
    set_div(1);
    cfg_period = 12'd3;
    fs_run = 1'b0;
    step();
    for (int i = 0; i < 40; i++) begin
      step();
      if (frame_start || fsync) bad++;
    end
    chk(bad == 0, "R4 frame counter stopped", bad, 0);
  endtask

  task automatic t_first();
    int n = 0;
    set_div(3);
    cfg_fs_auto = 1'b1;
    cfg_mode = 2'd0;
    cfg_period = 12'd9;
    cfg_width = 8'd2;
    fs_run = 1'b0;
    repeat (3) step();
    fs_run = 1'b1;
    step();
    while (!bit_tick && n < 20) begin step(); n++; end
    chk(frame_start == 1'b1, "R5 first strobe opens frame", int'(frame_start), 1);
  endtask

  task automatic t_auto();
    int nt, na, bad;
    set_div(1);
    fs_run = 1'b1;
    cfg_mode = 2'd0;
    cfg_period = 12'd9;
    cfg_width = 8'd2;
    measure_frame(nt, na);
    chk(nt == 10, "R6 period 9", nt, 10);
    chk(na == 3, "R7 width 2", na, 3);
    cfg_width = 8'd12;
    measure_frame(nt, na);
    chk(na == 10, "R7 width beyond period", na, 10);
    cfg_mode = 2'd3;
    cfg_period = 12'd5;
    cfg_width = 8'd0;
    fs_pol = 1'b1;
    measure_frame(nt, na);
    chk(nt == 6, "R6 mode 3 period 5", nt, 6);
    chk(na == 1, "R8 active-low width 0", na, 1);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (frame_start && !bit_tick) bad++;
    end
    chk(bad == 0, "R12 start aligned to strobe", bad, 0);
    fs_run = 1'b0;
    step(); step();
    chk(fsync == 1'b1, "R8 idle level active-low", int'(fsync), 1);
    fs_pol = 1'b0;
    step();
    chk(fsync == 1'b0, "R8 idle level active-high", int'(fsync), 0);
    fs_run = 1'b1;
  endtask

  task automatic t_symm();
    int nt, na;
    set_div(0);
    fs_run = 1'b1;
    cfg_mode = 2'd1;
    cfg_wbytes = 3'd2;
    cfg_period = 12'd3;
    cfg_width = 8'd1;
    measure_frame(nt, na);
    chk(nt == 32, "R9 symmetric 2 bytes period", nt, 32);
    chk(na == 16, "R9 symmetric 2 bytes width", na, 16);
    cfg_wbytes = 3'd0;
    measure_frame(nt, na);
    chk(nt == 16, "R9 symmetric 0 bytes period", nt, 16);
    chk(na == 8, "R9 symmetric 0 bytes width", na, 8);
  endtask

  task automatic t_clamp();
    int nt, na;
    set_div(0);
    fs_run = 1'b1;
    cfg_mode = 2'd2;
    cfg_period = 12'd5;
    cfg_width = 8'd3;
    measure_frame(nt, na);
    chk(nt == 33, "R10 low clamp", nt, 33);
    chk(na == 4, "R10 width kept", na, 4);
    cfg_period = 12'd100;
    measure_frame(nt, na);
    chk(nt == 101, "R10 in range", nt, 101);
    cfg_period = 12'd4095;
    cfg_width = 8'd10;
    measure_frame(nt, na);
    chk(nt == 4095, "R10 high clamp", nt, 4095);
    chk(na == 11, "R10 width at high clamp", na, 11);
  endtask

  task automatic t_write();
    int fs_cnt, act;
    set_div(1);
    fs_run = 1'b0;
    cfg_mode = 2'd0;
    cfg_period = 12'd9;
    cfg_width = 8'd3;
    cfg_fs_auto = 1'b0;
    step();
    fs_run = 1'b1;
    fs_cnt = 0; act = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (frame_start) fs_cnt++;
      if (bit_tick && fsync) act++;
    end
    chk(fs_cnt == 0 && act == 0, "R11 no frame without write", fs_cnt + act, 0);
    data_wr = 1'b1;
    step();
    data_wr = 1'b0;
    fs_cnt = 0; act = 0;
    for (int i = 0; i < 80; i++) begin
      if (frame_start) fs_cnt++;
      if (bit_tick && fsync) act++;
      step();
    end
    chk(fs_cnt == 1, "R11 one frame per write", fs_cnt, 1);
    chk(act == 4, "R11 width after write", act, 4);
    chk(fsync == 1'b0, "R11 inactive after frame", int'(fsync), 0);
    cfg_fs_auto = 1'b1;
  endtask

  initial begin
    t_reset();
    t_divider();
    t_bclk();
    t_gen_stop();
    t_fs_stop();
    t_first();
    t_auto();
    t_symm();
    t_clamp();
    t_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule